// File: doc/BRIEF.md
# Key-Armed Watchdog Timer

This block is a hardware watchdog for a small microcontroller. It stays idle after reset. Software starts it with a two-byte unlock sequence written to its key register. Once running, it counts machine-cycle strobes. If software does not repeat the unlock sequence before the selected interval ends, the block drives a reset pulse of fixed length. After that pulse it is idle again.

The timeout is chosen by a 3-bit period field in a second register. Software must set the field before arming, because the field is frozen while the watchdog runs. Nothing written to the block can stop a running watchdog; only the synchronous reset input or the block's own overflow stops it.

Both registers share one write port: a write strobe, a register select and a data byte. The port has no back-pressure: every strobed write is taken in the cycle it is presented. The reset output is a plain level, not a stream.

Top module: `wdog_top`

## Requirements
- R1: After `srst`, the watchdog is idle, `rst_pulse` is low and the period field is 0. No number of `mc_tick` strobes raises `rst_pulse` until the block is armed.
- R2: The watchdog arms when the key register (`wr_sel`=0) receives byte 8'h1E and then byte 8'hE1 on the next strobed write. A write to the period register (`wr_sel`=1) between the two bytes discards the partial sequence.
- R3: While armed, each `mc_tick` advances the count by one. Key writes that do not form the sequence, such as 8'h00 or 8'hFF, do not stop it. Only `srst` or an overflow disarms it.
- R4: The timeout is 2^(BASE_W+N) strobes, where N is `wr_data[2:0]` written to the period register. With the default BASE_W of 14, this runs from 16384 strobes at N=0 to 2^21 strobes at N=7. `rst_pulse` goes high on the clock edge that takes the final strobe.
- R5: While armed, writes to the period register are ignored. The running timeout keeps the value of N that was set before arming.
- R6: `rst_pulse` stays high for exactly PULSE_LEN clock cycles (96 by default), counted on the clock and not on strobes. The block then returns to its reset state: idle, with period 0.
- R7: Writing the 8'h1E, 8'hE1 sequence while armed clears the count to zero and keeps the watchdog armed. A full timeout is then needed again.
- R8: While `rst_pulse` is high, writes to either register have no effect. After the pulse the block is idle, with period 0.
- R9: If a key byte other than 8'hE1 follows 8'h1E, the tracker returns to waiting. A repeated 8'h1E restarts the sequence, so the writes 1E, 1E, E1 arm the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| srst | input | 1 | Synchronous reset, active high |
| mc_tick | input | 1 | Machine-cycle strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = key register, 1 = period register |
| wr_data | input | 8 | Write data byte |
| rst_pulse | output | 1 | Reset pulse output, active high |

## Verification
A strobe counts only when `mc_tick` is high across a rising edge. The bench drives each strobe for one cycle and tallies it at the next falling edge. On the terminal strobe, `rst_pulse` rises at that same edge, so the first falling edge after it must show the output high with the tally exactly 2^(BASE_W+N). The pulse width is the number of falling edges at which `rst_pulse` reads high, and it must be 96. Each write takes one cycle, with the strobe held low during writes, so an arm or service write adds no strobe to the count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_BYTE_A = 8'h1E;
  localparam logic [7:0] KEY_BYTE_B = 8'hE1;
  localparam logic       SEL_KEY    = 1'b0;
  localparam logic       SEL_PERIOD = 1'b1;

  typedef enum logic {
    KS_WAIT = 1'b0,
    KS_HALF = 1'b1
  } key_state_t;
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  logic       clr,
  input  logic       blocked,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       unlock
);
  key_state_t st_q, st_d;
  logic       wr_live;

  assign wr_live = wr_en & ~blocked;
  assign unlock  = wr_live & (wr_sel == SEL_KEY) & (st_q == KS_HALF) &
                   (wr_data == KEY_BYTE_B);

  always_comb begin
    st_d = st_q;
    if (clr) begin
      st_d = KS_WAIT;
    end else if (wr_live) begin
      if (wr_sel == SEL_KEY && wr_data == KEY_BYTE_A) st_d = KS_HALF;
      else                                             st_d = KS_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (srst) st_q <= KS_WAIT;
    else      st_q <= st_d;
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int BASE_W = 14,
  parameter int PRE_W  = 7,
  parameter int PER_W  = 3
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              run,
  input  logic              tick,
  input  logic              clear,
  input  logic [PER_W-1:0]  period,
  output logic              terminal,
  output logic [BASE_W-1:0] base_q,
  output logic [PRE_W-1:0]  pre_q
);
  logic [PRE_W-1:0] pmask;
  logic             base_full;
  logic             pre_full;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign pmask[i] = (32'(period) > i);
  end

  assign base_full = &base_q;
  assign pre_full  = &(pre_q | ~pmask);
  assign terminal  = run & tick & base_full & pre_full;

  always_ff @(posedge clk) begin
    if (srst || clear) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (run && tick) begin
      base_q <= base_q + 1'b1;
      if (base_full) pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 96
) (
  input  logic clk,
  input  logic srst,
  input  logic start,
  output logic active
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= '0;
    end else if (active) begin
      if (cnt_q == CW'(LEN - 1)) active <= 1'b0;
      else                       cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_W    = 14,
  parameter int PRE_W     = 7,
  parameter int PER_W     = 3,
  parameter int PULSE_LEN = 96
) (
  input  logic       clk,
  input  logic       srst,
  input  logic       mc_tick,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       rst_pulse
);
  logic              unlock;
  logic              armed_q;
  logic [PER_W-1:0]  period_q;
  logic              term_raw;
  logic              overflow;
  logic [BASE_W-1:0] base_q;
  logic [PRE_W-1:0]  pre_q;

  // a service write in the terminal cycle wins over the overflow
  assign overflow = term_raw & ~unlock;

  wdog_key_seq u_key (
    .clk     (clk),
    .srst    (srst),
    .clr     (overflow),
    .blocked (rst_pulse),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .unlock  (unlock)
  );

  wdog_count #(.BASE_W(BASE_W), .PRE_W(PRE_W), .PER_W(PER_W)) u_cnt (
    .clk      (clk),
    .srst     (srst),
    .run      (armed_q),
    .tick     (mc_tick),
    .clear    (unlock | overflow),
    .period   (period_q),
    .terminal (term_raw),
    .base_q   (base_q),
    .pre_q    (pre_q)
  );

  wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk    (clk),
    .srst   (srst),
    .start  (overflow),
    .active (rst_pulse)
  );

  always_ff @(posedge clk) begin
    if (srst || overflow) begin
      armed_q  <= 1'b0;
      period_q <= '0;
    end else begin
      if (unlock) armed_q <= 1'b1;
      if (wr_en && wr_sel == SEL_PERIOD && !armed_q && !rst_pulse)
        period_q <= wr_data[PER_W-1:0];
    end
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int BASE_W    = 14,
  parameter int PRE_W     = 7,
  parameter int PER_W     = 3,
  parameter int PULSE_LEN = 96
) (
  input logic              clk,
  input logic              srst,
  input logic              unlock,
  input logic              armed_q,
  input logic [PER_W-1:0]  period_q,
  input logic [BASE_W-1:0] base_q,
  input logic [PRE_W-1:0]  pre_q,
  input logic              rst_pulse
);
  localparam int HW = $clog2(PULSE_LEN + 1);
  logic [HW-1:0] hi_cnt = '0;
  logic          srst_d = 1'b0;

  always_ff @(posedge clk) begin
    srst_d <= srst;
    if (srst || !rst_pulse) hi_cnt <= '0;
    else                    hi_cnt <= hi_cnt + 1'b1;
  end

  // R1: the cycle after a reset the output is low
  always @(posedge clk) begin
    if (srst_d) a_r1_reset_low: assert (!rst_pulse);
  end

  a_r6_pulse_hold: assert property (@(posedge clk) disable iff (srst)
    (rst_pulse && hi_cnt < HW'(PULSE_LEN - 1)) |=> rst_pulse);

  a_r6_pulse_end: assert property (@(posedge clk) disable iff (srst)
    (rst_pulse && hi_cnt == HW'(PULSE_LEN - 1)) |=> !rst_pulse);

  a_r4_rise_from_armed: assert property (@(posedge clk) disable iff (srst)
    $rose(rst_pulse) |-> $past(armed_q));

  a_r8_pulse_disarmed: assert property (@(posedge clk) disable iff (srst)
    rst_pulse |-> !armed_q);

  a_r5_period_locked: assert property (@(posedge clk) disable iff (srst)
    (armed_q && $past(armed_q)) |-> $stable(period_q));

  a_r7_service_clear: assert property (@(posedge clk) disable iff (srst)
    unlock |=> (base_q == '0 && pre_q == '0));
endmodule

bind wdog_top wdog_checker #(
  .BASE_W(BASE_W), .PRE_W(PRE_W), .PER_W(PER_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk       (clk),
  .srst      (srst),
  .unlock    (unlock),
  .armed_q   (armed_q),
  .period_q  (period_q),
  .base_q    (base_q),
  .pre_q     (pre_q),
  .rst_pulse (rst_pulse)
);

// File: tb/wdog_top_bench.sv
module wdog_top_bench;
  localparam int BW  = 4;
  localparam int PL  = 96;

  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic       mc_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rst_pulse;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  wdog_top #(.BASE_W(BW), .PRE_W(7), .PER_W(3), .PULSE_LEN(PL)) u_wdog_top (
    .clk(clk), .srst(srst), .mc_tick(mc_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rst_pulse(rst_pulse)
  );

  function automatic int tmo(input int n);
    return 1 << (BW + n);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic arm();
    wr(1'b0, 8'h1E);
    wr(1'b0, 8'hE1);
  endtask

  task automatic do_reset();
    srst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    srst = 1'b0;
  endtask

  task automatic run_ticks(input int limit, output int ticks, output bit fired);
    ticks = 0; fired = 1'b0;
    while (!fired && ticks < limit) begin
      mc_tick = (($urandom % 4) != 0);
      @(negedge clk);
      if (mc_tick) ticks++;
      if (rst_pulse) fired = 1'b1;
    end
    mc_tick = 1'b0;
  endtask

  // called at the first falling edge with the pulse high
  task automatic pulse_width(output int w, input bit poke);
    w = 1;
    while (w < 400) begin
      mc_tick = $urandom % 2;
      if (poke && w == 10) wr(1'b1, 8'h05);
      else if (poke && w == 20) wr(1'b0, 8'h1E);
      else if (poke && w == 21) wr(1'b0, 8'hE1);
      else @(negedge clk);
      if (rst_pulse) w++;
      else break;
    end
    mc_tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t;
    int w;
    bit f;
    void'($urandom(32'd4177));
    @(negedge clk);
    do_reset();

    // R1: reset state and idle behaviour
    check("R1 reset output", int'(rst_pulse), 0);
    run_ticks(300, t, f);
    check("R1 no pulse while idle", int'(f), 0);

    // R2: period write between the key bytes discards the sequence
    wr(1'b0, 8'h1E); wr(1'b1, 8'h00); wr(1'b0, 8'hE1);
    run_ticks(300, t, f);
    check("R2 interrupted sequence not armed", int'(f), 0);

    // R9: wrong second byte returns tracker to wait
    wr(1'b0, 8'h1E); wr(1'b0, 8'h55); wr(1'b0, 8'hE1);
    run_ticks(300, t, f);
    check("R9 wrong byte not armed", int'(f), 0);

    // R9: 1E 1E E1 arms, R4 timeout at N=0
    wr(1'b0, 8'h1E); wr(1'b0, 8'h1E); wr(1'b0, 8'hE1);
    run_ticks(tmo(0) + 10, t, f);
    check("R9 restart arms", int'(f), 1);
    check("R4 timeout N=0", t, tmo(0));
    pulse_width(w, 1'b0);
    check("R6 pulse width", w, PL);

    // R4 and R6 for every period value
    for (int n = 0; n < 8; n++) begin
      wr(1'b1, 8'(n) | 8'hF8);
      arm();
      run_ticks(tmo(n) + 10, t, f);
      check($sformatf("R4 timeout N=%0d", n), t, tmo(n));
      pulse_width(w, 1'b0);
      check("R6 pulse width", w, PL);
    end

    // R5: period locked while armed; R3 junk key writes do not stop it
    wr(1'b1, 8'h02);
    arm();
    wr(1'b1, 8'h07);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'hFF);
    run_ticks(tmo(7), t, f);
    check("R5 period locked timeout", t, tmo(2));
    check("R3 still armed after junk", int'(f), 1);
    // R8: writes during pulse ignored, R6 period back to 0
    pulse_width(w, 1'b1);
    check("R8 pulse width with writes", w, PL);
    run_ticks(300, t, f);
    check("R8 key during pulse did not arm", int'(f), 0);
    arm();
    run_ticks(tmo(7), t, f);
    check("R6 period back to 0 after pulse", t, tmo(0));
    pulse_width(w, 1'b0);

    // R7: service restarts the count
    wr(1'b1, 8'h01);
    arm();
    run_ticks(20, t, f);
    check("R7 no pulse before service", int'(f), 0);
    arm();
    run_ticks(100, t, f);
    check("R7 full timeout after service", t, tmo(1));
    pulse_width(w, 1'b0);

    // R3: only reset disarms
    wr(1'b1, 8'h01);
    arm();
    run_ticks(10, t, f);
    do_reset();
    run_ticks(400, t, f);
    check("R3 reset disarms", int'(f), 0);

    // R7 random: services at random points, then timeout
    for (int k = 0; k < 6; k++) begin
      int n = $urandom % 4;
      int s = $urandom % 3;
      wr(1'b1, 8'(n));
      arm();
      for (int j = 0; j < s; j++) begin
        run_ticks(1 + ($urandom % (tmo(n) - 1)), t, f);
        check("R7 no early pulse", int'(f), 0);
        arm();
      end
      run_ticks(tmo(n) + 10, t, f);
      check("R7 random timeout", t, tmo(n));
      pulse_width(w, 1'b0);
      check("R6 random pulse width", w, PL);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule